// File: doc/BRIEF.md
# Inverse Transform Multiply-Accumulate Engine

This block computes one-dimensional inverse transforms by matrix-vector accumulation. Each cycle it takes up to two signed residual coefficients. It multiplies each one by a row of the transform matrix, which it reads from an internal coefficient table. It adds the products into a vector of running sums held in feedback registers. When the last coefficient of a vector has arrived, the finished sums move into a drain bank. The drain bank emits two rounded, saturated samples per cycle while the next vector is already being accumulated.

Three kernels are supported: 4-point and 8-point inverse DCT-II, and a 4-point sine family. The sine family is inverse DST-VII, plus inverse DCT-VIII, which is derived from the DST-VII table by mirroring columns and flipping the sign of odd rows. In zeroed mode only the low-frequency half of the coefficients is non-zero. One coefficient per cycle then enters on both multiplier lanes, and the vector still takes N/2 input cycles for N outputs.

Top module: `tx_accum_engine`

## Requirements
- R1: After reset `valid_o` is low and `y0_o`/`y1_o` are 0; `valid_o` stays low until a vector has completed.
- R2: With `type_i`=0 (DCT-II), `size_i`=0 and `dup_i`=0, a 4-point vector takes 2 input cycles. Cycle k carries coefficient 2k on `x0_i` and 2k+1 on `x1_i`. Output j is the sum over i of c[i]·M[i][j], with M the integer 4-point DCT-II matrix (rows 64/83/36 based).
- R3: `type_i`=0 with `size_i`=1 gives an 8-point inverse DCT-II (odd rows 89/75/50/18) over 4 input cycles.
- R4: `type_i`=2 gives a 4-point inverse DST-VII (values 29/55/74/84).
- R5: `type_i`=1 gives a 4-point inverse DCT-VIII, whose matrix entry [i][j] equals (-1)^i times DST-VII entry [i][3-j].
- R6: With `dup_i`=1 the vector still takes N/2 input cycles. Cycle k carries coefficient k on `x0_i`, higher coefficients are taken as zero, and `x1_i` has no effect.
- R7: Each output equals the accumulated sum plus 64, arithmetically shifted right by 7.
- R8: Results above 32767 or below -32768 saturate to those limits.
- R9: `valid_o` rises in the cycle after the edge that takes a vector's last input. It then stays high for N/2 cycles, delivering outputs (0,1), (2,3), … in order on (`y0_o`, `y1_o`).
- R10: A new vector may start in the cycle after the previous one's last input. Its first pair restarts the sums, and output is continuous with no gap.
- R11: `type_i`, `size_i` and `dup_i` are sampled only on a vector's first input cycle; their values on later cycles of the same vector are ignored.
- R12: If a vector completes while an earlier vector is still draining, the new result replaces the rest of the earlier one.
- R13: The sine family (`type_i` 1 or 2) is always 4-point regardless of `size_i`, and `type_i`=3 acts as DCT-II.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input coefficient(s) present this cycle |
| dup_i | input | 1 | Zeroed mode: one coefficient per cycle on both lanes |
| size_i | input | 1 | 0: 4-point, 1: 8-point (DCT-II only) |
| type_i | input | 2 | 0/3: DCT-II, 1: DCT-VIII, 2: DST-VII |
| x0_i | input | 16 | Signed coefficient, lane 0 |
| x1_i | input | 16 | Signed coefficient, lane 1 |
| valid_o | output | 1 | Output pair present |
| y0_o | output | 16 | Signed result, even index |
| y1_o | output | 16 | Signed result, odd index |

## Verification
Two things can land on the same clock edge: the drain bank capturing a freshly finished vector, and the emission of the previous vector's last output pair. The bench provokes this with back-to-back 4-point vectors, where capture and the end of the drain coincide and the output must run without a gap. It also sends an 8-point vector followed immediately by a 4-point one, so the capture arrives mid-drain. A scoreboard queue holds the expected pairs in order. Any missing, extra or reordered pair shows up as a mismatch against the independently computed matrix products.

// File: rtl/tx_accum_pkg.sv
package tx_accum_pkg;

  typedef enum logic [1:0] {
    TK_DCT2     = 2'd0,
    TK_DCT8     = 2'd1,
    TK_DST7     = 2'd2,
    TK_DCT2_ALT = 2'd3
  } tx_kind_e;

  // 4-point sine kernel, row = frequency, col = sample
  function automatic int sine4(input int r, input int c);
    case ({r[1:0], c[1:0]})
      4'h0: return 29;  4'h1: return 55;  4'h2: return 74;  4'h3: return 84;
      4'h4: return 74;  4'h5: return 74;  4'h6: return 0;   4'h7: return -74;
      4'h8: return 84;  4'h9: return -29; 4'hA: return -74; 4'hB: return 55;
      4'hC: return 55;  4'hD: return -84; 4'hE: return 74;  default: return -29;
    endcase
  endfunction

  // 8-point cosine kernel from folded angle index
  function automatic int cos8(input int r, input int c);
    int m;
    int sg;
    int mag;
    if (r == 0) return 64;
    m  = (r * (2 * c + 1)) % 32;
    sg = 1;
    if (m > 16) m = 32 - m;
    if (m > 8) begin
      m  = 16 - m;
      sg = -1;
    end
    case (m)
      1: mag = 89;
      2: mag = 83;
      3: mag = 75;
      4: mag = 64;
      5: mag = 50;
      6: mag = 36;
      7: mag = 18;
      default: mag = 0;
    endcase
    return sg * mag;
  endfunction

  function automatic int coef_of(input tx_kind_e kind, input logic big, input int r, input int c);
    case (kind)
      TK_DCT8: begin
        if (r > 3 || c > 3) return 0;
        return (r % 2 == 1) ? -sine4(r, 3 - c) : sine4(r, 3 - c);
      end
      TK_DST7: begin
        if (r > 3 || c > 3) return 0;
        return sine4(r, c);
      end
      default: begin
        if (big) return cos8(r, c);
        if (r > 3 || c > 3) return 0;
        return cos8(2 * r, c);
      end
    endcase
  endfunction

endpackage

// File: rtl/tx_coef_rom.sv
module tx_coef_rom
  import tx_accum_pkg::*;
#(
  parameter int NMAX = 8,
  parameter int CW   = 8,
  parameter int RW   = $clog2(NMAX)
) (
  input  tx_kind_e                  kind_i,
  input  logic                      big_i,
  input  logic                      dup_i,
  input  logic [RW-1:0]             row0_i,
  input  logic [RW-1:0]             row1_i,
  output logic [NMAX-1:0][CW-1:0]   c0_o,
  output logic [NMAX-1:0][CW-1:0]   c1_o
);

  for (genvar g = 0; g < NMAX; g++) begin : g_col
    assign c0_o[g] = CW'(coef_of(kind_i, big_i, int'(row0_i), g));
    // lane 1 is silent when one sample feeds both lanes
    assign c1_o[g] = dup_i ? '0 : CW'(coef_of(kind_i, big_i, int'(row1_i), g));
  end

endmodule

// File: rtl/tx_mac_bank.sv
module tx_mac_bank #(
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int AW   = 32,
  parameter int NMAX = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      clr_i,
  input  logic signed [DW-1:0]      x0_i,
  input  logic signed [DW-1:0]      x1_i,
  input  logic [NMAX-1:0][CW-1:0]   c0_i,
  input  logic [NMAX-1:0][CW-1:0]   c1_i,
  output logic [NMAX-1:0][AW-1:0]   sum_o
);

  localparam int PW = DW + CW;

  for (genvar g = 0; g < NMAX; g++) begin : g_mac
    logic signed [PW-1:0] p0, p1;
    logic [AW-1:0]        acc_q;

    assign p0 = x0_i * $signed(c0_i[g]);
    assign p1 = x1_i * $signed(c1_i[g]);
    assign sum_o[g] = (clr_i ? '0 : acc_q) + AW'(p0) + AW'(p1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (en_i) acc_q <= sum_o[g];
    end
  end

endmodule

// File: rtl/tx_drain.sv
module tx_drain #(
  parameter int DW   = 16,
  parameter int AW   = 32,
  parameter int NMAX = 8,
  parameter int RS   = 7,
  parameter int CNTW = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_i,
  input  logic [CNTW-1:0]           last_idx_i,
  input  logic [NMAX-1:0][AW-1:0]   sum_i,
  output logic                      valid_o,
  output logic [DW-1:0]             y0_o,
  output logic [DW-1:0]             y1_o
);

  localparam logic signed [AW-1:0] HI  = AW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] LO  = -AW'(64'sd1 <<< (DW - 1));
  localparam logic signed [AW-1:0] RND = AW'(64'sd1 <<< (RS - 1));

  logic [NMAX-1:0][AW-1:0] hold_q;
  logic [CNTW-1:0]         dcnt_q, dlast_q;
  logic                    act_q;
  logic [CNTW:0]           idx;

  function automatic logic [DW-1:0] round_sat(input logic [AW-1:0] v);
    logic signed [AW-1:0] t;
    t = ($signed(v) + RND) >>> RS;
    if (t > HI)      return HI[DW-1:0];
    else if (t < LO) return LO[DW-1:0];
    else             return t[DW-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      dcnt_q  <= '0;
      dlast_q <= '0;
      act_q   <= 1'b0;
    end else if (cap_i) begin
      // capture wins over an unfinished drain
      hold_q  <= sum_i;
      dcnt_q  <= '0;
      dlast_q <= last_idx_i;
      act_q   <= 1'b1;
    end else if (act_q) begin
      if (dcnt_q == dlast_q) act_q <= 1'b0;
      else                   dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign idx     = {dcnt_q, 1'b0};
  assign valid_o = act_q;
  assign y0_o    = round_sat(hold_q[idx]);
  assign y1_o    = round_sat(hold_q[idx | 1'b1]);

endmodule

// File: rtl/tx_accum_engine.sv
module tx_accum_engine
  import tx_accum_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int AW   = 32,
  parameter int NMAX = 8,
  parameter int RS   = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          dup_i,
  input  logic          size_i,
  input  logic [1:0]    type_i,
  input  logic [DW-1:0] x0_i,
  input  logic [DW-1:0] x1_i,
  output logic          valid_o,
  output logic [DW-1:0] y0_o,
  output logic [DW-1:0] y1_o
);

  localparam int RW         = $clog2(NMAX);
  localparam int CNTW       = RW - 1;
  localparam int LAST_BIG   = NMAX / 2 - 1;
  localparam int LAST_SMALL = NMAX / 4 - 1;

  logic [CNTW-1:0] cnt_q, last_idx;
  tx_kind_e        kind_q, kind_in, kind_e;
  logic            big_q, dup_q, big_e, dup_e;
  logic            first, cap, is_cos;
  logic [RW-1:0]   row0, row1;
  logic [DW-1:0]   xb;

  logic [NMAX-1:0][CW-1:0] coef0, coef1;
  logic [NMAX-1:0][AW-1:0] sum;

  assign kind_in  = tx_kind_e'(type_i);
  assign is_cos   = (kind_in == TK_DCT2) || (kind_in == TK_DCT2_ALT);
  assign first    = (cnt_q == '0);
  assign kind_e   = first ? kind_in : kind_q;
  assign big_e    = first ? (size_i & is_cos) : big_q;
  assign dup_e    = first ? dup_i : dup_q;
  assign last_idx = big_e ? CNTW'(LAST_BIG) : CNTW'(LAST_SMALL);
  assign cap      = valid_i && (cnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= TK_DCT2;
      big_q  <= 1'b0;
      dup_q  <= 1'b0;
    end else if (valid_i) begin
      if (first) begin
        kind_q <= kind_in;
        big_q  <= big_e;
        dup_q  <= dup_i;
      end
      cnt_q <= cap ? '0 : cnt_q + 1'b1;
    end
  end

  // pair mode: rows 2k/2k+1; zeroed mode: row k on lane 0 only
  assign row0 = dup_e ? RW'(cnt_q) : {cnt_q, 1'b0};
  assign row1 = {cnt_q, 1'b1};
  assign xb   = dup_e ? x0_i : x1_i;

  tx_coef_rom #(.NMAX(NMAX), .CW(CW), .RW(RW)) u_rom (
    .kind_i (kind_e),
    .big_i  (big_e),
    .dup_i  (dup_e),
    .row0_i (row0),
    .row1_i (row1),
    .c0_o   (coef0),
    .c1_o   (coef1)
  );

  tx_mac_bank #(.DW(DW), .CW(CW), .AW(AW), .NMAX(NMAX)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .clr_i  (first),
    .x0_i   ($signed(x0_i)),
    .x1_i   ($signed(xb)),
    .c0_i   (coef0),
    .c1_i   (coef1),
    .sum_o  (sum)
  );

  tx_drain #(.DW(DW), .AW(AW), .NMAX(NMAX), .RS(RS), .CNTW(CNTW)) u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .last_idx_i (last_idx),
    .sum_i      (sum),
    .valid_o    (valid_o),
    .y0_o       (y0_o),
    .y1_o       (y1_o)
  );

endmodule

// File: rtl/tx_accum_engine_chk.sv
module tx_accum_engine_chk #(
  parameter int NMAX = 8,
  parameter int CW   = 8,
  parameter int CNTW = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic                    cap,
  input logic [CNTW-1:0]         cnt_q,
  input logic [3:0]              cfg_q,
  input logic                    dup_e,
  input logic [NMAX-1:0][CW-1:0] coef1
);

  a_r1_quiet_without_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !cap) |=> !valid_o);

  a_r9_capture_starts_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> valid_o);

  a_r9_rise_needs_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(cap));

  a_r6_lane1_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dup_e) |-> (coef1 == '0));

  a_r11_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_q != '0) |=> $stable(cfg_q));

endmodule

bind tx_accum_engine tx_accum_engine_chk #(.NMAX(NMAX), .CW(CW), .CNTW(CNTW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .cap     (cap),
  .cnt_q   (cnt_q),
  .cfg_q   ({kind_q, big_q, dup_q}),
  .dup_e   (dup_e),
  .coef1   (coef1)
);

// File: tb/tx_accum_engine_test.sv
module tx_accum_engine_test;

  typedef struct {
    int    e0;
    int    e1;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, dup_i = 1'b0, size_i = 1'b0;
  logic [1:0]  type_i = 2'd0;
  logic [15:0] x0_i = '0, x1_i = '0;
  logic        valid_o;
  logic [15:0] y0_o, y1_o;

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  tx_accum_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .dup_i(dup_i),
    .size_i(size_i), .type_i(type_i), .x0_i(x0_i), .x1_i(x1_i),
    .valid_o(valid_o), .y0_o(y0_o), .y1_o(y1_o)
  );

  int d8[8][8] = '{
    '{64, 64, 64, 64, 64, 64, 64, 64},
    '{89, 75, 50, 18, -18, -50, -75, -89},
    '{83, 36, -36, -83, -83, -36, 36, 83},
    '{75, -18, -89, -50, 50, 89, 18, -75},
    '{64, -64, -64, 64, 64, -64, -64, 64},
    '{50, -89, 18, 75, -75, -18, 89, -50},
    '{36, -83, 83, -36, -36, 83, -83, 36},
    '{18, -50, 75, -89, 89, -75, 50, -18}};
  int d4[4][4] = '{'{64, 64, 64, 64}, '{83, 36, -36, -83}, '{64, -64, -64, 64}, '{36, -83, 83, -36}};
  int s7[4][4] = '{'{29, 55, 74, 84}, '{74, 74, 0, -74}, '{84, -29, -74, 55}, '{55, -84, 74, -29}};
  int c8[4][4] = '{'{84, 74, 55, 29}, '{74, 0, -74, -74}, '{55, -74, -29, 84}, '{29, -74, 84, -55}};

  function automatic int mat(int kind, int n, int i, int j);
    if (kind == 1) return c8[i][j];
    if (kind == 2) return s7[i][j];
    return (n == 8) ? d8[i][j] : d4[i][j];
  endfunction

  function automatic int rnd_sat(int v);
    int t;
    t = (v + 64) >>> 7;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: push expected pairs, then drive the vector
  task automatic send_vec(int kind, int size, bit dup, int c[8], int junk, int keep,
                          string req, bit scramble);
    int n, h, acc;
    int ce[8];
    int y[8];
    exp_t e;
    n = ((kind == 0 || kind == 3) && size == 1) ? 8 : 4;
    h = n / 2;
    for (int i = 0; i < 8; i++) ce[i] = (i < n && (!dup || i < h)) ? c[i] : 0;
    for (int j = 0; j < n; j++) begin
      acc = 0;
      for (int i = 0; i < n; i++) acc += ce[i] * mat(kind, n, i, j);
      y[j] = rnd_sat(acc);
    end
    for (int m = 0; m < h && m < keep; m++) begin
      e.e0 = y[2*m]; e.e1 = y[2*m+1]; e.req = req;
      q.push_back(e);
    end
    for (int k = 0; k < h; k++) begin
      @(negedge clk);
      valid_i = 1'b1;
      if (k == 0 || !scramble) begin
        type_i = 2'(kind); size_i = size[0]; dup_i = dup;
      end else begin
        type_i = 2'(kind + 1); size_i = ~size[0]; dup_i = ~dup;
      end
      x0_i = dup ? 16'(c[k]) : 16'(c[2*k]);
      x1_i = dup ? 16'(junk) : 16'(c[2*k+1]);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      x0_i = 16'h5a5a; x1_i = 16'ha5a5;
      type_i = 2'd2; size_i = 1'b1; dup_i = 1'b1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      if (q.size() == 0) begin
        check(0, "R9", "unexpected output pair", $signed(y0_o), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check($signed(y0_o) == e.e0, e.req, "y0", $signed(y0_o), e.e0);
        check($signed(y1_o) == e.e1, e.req, "y1", $signed(y1_o), e.e1);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o == 1'b0, "R1", "valid_o in reset", int'(valid_o), 0);
    check(y0_o == 16'd0, "R1", "y0 in reset", $signed(y0_o), 0);
    rst_n = 1'b1;
    idle(4);
    check(valid_o == 1'b0, "R1", "valid_o idle", int'(valid_o), 0);

    send_vec(0, 0, 0, '{100, -50, 25, 7, 0, 0, 0, 0}, 0, 8, "R2", 0);  idle(4);
    send_vec(0, 0, 0, '{-300, 1200, -77, 4000, 0, 0, 0, 0}, 0, 8, "R2", 0); idle(4);
    send_vec(0, 1, 0, '{500, -400, 300, -200, 100, 60, -30, 9}, 0, 8, "R3", 0); idle(6);
    send_vec(0, 1, 0, '{-1, 2000, 0, -2000, 777, 0, 13, -4000}, 0, 8, "R3", 0); idle(6);
    send_vec(2, 0, 0, '{123, -456, 789, -1011, 0, 0, 0, 0}, 0, 8, "R4", 0); idle(4);
    send_vec(1, 0, 0, '{123, -456, 789, -1011, 0, 0, 0, 0}, 0, 8, "R5", 0); idle(4);
    send_vec(1, 0, 0, '{-900, 50, 3, 250, 0, 0, 0, 0}, 0, 8, "R5", 0);      idle(4);
    // R6: zeroed mode, lane 1 carries junk
    send_vec(0, 1, 1, '{1000, -700, 350, 90, 0, 0, 0, 0}, 12345, 8, "R6", 0); idle(6);
    send_vec(2, 0, 1, '{-2500, 640, 0, 0, 0, 0, 0, 0}, -9999, 8, "R6", 0);   idle(4);
    // R7: small values exercise rounding
    send_vec(2, 0, 0, '{-3, 2, 1, -1, 0, 0, 0, 0}, 0, 8, "R7", 0); idle(4);
    send_vec(0, 0, 0, '{1, 0, 0, 1, 0, 0, 0, 0}, 0, 8, "R7", 0);   idle(4);
    // R8: saturation both ways
    send_vec(0, 0, 0, '{32767, 32767, 32767, 32767, 0, 0, 0, 0}, 0, 8, "R8", 0); idle(4);
    send_vec(0, 1, 0, '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
             0, 8, "R8", 0); idle(6);
    // R10: back-to-back vectors, continuous output
    send_vec(0, 0, 0, '{400, 300, 200, 100, 0, 0, 0, 0}, 0, 8, "R10", 0);
    send_vec(2, 0, 0, '{-400, 30, 2000, -10, 0, 0, 0, 0}, 0, 8, "R10", 0);
    send_vec(1, 0, 0, '{77, 88, -99, 11, 0, 0, 0, 0}, 0, 8, "R10", 0);
    idle(4);
    // R11: configuration changes after first cycle are ignored
    send_vec(0, 1, 0, '{210, -310, 410, -510, 610, -710, 810, -910}, 0, 8, "R11", 1); idle(6);
    send_vec(2, 0, 1, '{1500, -1500, 0, 0, 0, 0, 0, 0}, 4242, 8, "R11", 1); idle(4);
    // R12: 8-point then immediately 4-point truncates the first drain
    send_vec(0, 1, 0, '{900, 800, 700, 600, 500, 400, 300, 200}, 0, 2, "R12", 0);
    send_vec(0, 0, 0, '{-900, 80, -7, 6000, 0, 0, 0, 0}, 0, 8, "R12", 0);
    idle(6);
    // R13: sine ignores size select; type 3 acts as DCT-II
    send_vec(2, 1, 0, '{640, -320, 160, -80, 0, 0, 0, 0}, 0, 8, "R13", 0); idle(4);
    send_vec(3, 1, 0, '{64, 128, -256, 512, -1024, 2048, -4096, 8192}, 0, 8, "R13", 0);
    idle(12);
    check(q.size() == 0, "R9", "pairs never produced", q.size(), 0);
    finish_run();
  end

endmodule